// File: doc/BRIEF.md
# Stochastic Hybrid Dot-Product Lane

This block computes an approximate dot product of a short vector of unsigned 8-bit activations with an equally long vector of unsigned 8-bit weights. It does the arithmetic on pseudo-random bitstreams. Each operand becomes a stream whose fraction of ones equals operand/256. Two such streams are multiplied by a per-cycle AND. The product streams are merged in small groups by a stochastic adder, and each group output is counted by an exact binary counter.

Software-side logic loads the operands one at a time. It then pulses `start` with a length code. The lane runs for the chosen number of cycles and raises `done` for one cycle. `result` then holds the sum of the group counters. A long stream gives a tighter estimate. A short stream finishes sooner and costs fewer toggles. The same operands can be rerun at a different length.

All comparators draw their random value from one shared 8-bit LFSR. Activation comparators see the state as it is. Weight comparators see the state with its bit order reversed. A mode bit chosen at start selects the group adder. One option is a saturating OR merge. The other is a scaled merge that forwards one product per cycle, picked by low LFSR bits.

Top module: `sc_mac_lane`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done` and `result` are all zero.
- R2: In each run cycle with random value r, a lane's activation bit is 1 exactly when activation > r. Its weight bit is 1 exactly when weight > bitreverse(r), where bit 7 swaps with bit 0, bit 6 with bit 1, and so on. The lane's product bit is the AND of the two.
- R3: The LFSR is 8 bits. Each step shifts the state left by one and puts s[7]^s[5]^s[4]^s[3] into bit 0. Each accepted start reseeds it to the parameter SEED (default 0xA5). The first run cycle uses SEED, and each later run cycle uses the next state. The state is never zero.
- R4: With `merge_mux` = 0 at start, a group's bit in a cycle is the OR of its GROUP product bits. Lanes 4g to 4g+3 form group g.
- R5: With `merge_mux` = 1 at start, a group's bit in a cycle is the product bit of lane 4g+k. Here k is the value of bits 1:0 of that cycle's random value.
- R6: `len_code` values 0,1,2,3,4 select 16,32,64,128,256 run cycles, and values 5 to 7 select 256. `busy` is high for exactly that many cycles. `done` is high for exactly one cycle, the cycle after the last run cycle.
- R7: When `done` is high, `result` equals the sum over groups of the number of run cycles whose group bit was 1. It keeps that value until the next accepted start.
- R8: A `start` while `busy` is high is ignored and does not lengthen the run. An operand load while `busy` is high is ignored, so it affects neither the current nor any later run.
- R9: All-zero operands give a result of 0. Operands equal to 255 give ones on every cycle except those where the compared random value is 255.
- R10: At length 256 in OR mode, with one nonzero lane per group, `result` is within 6 of sum(activation·weight)/256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Write one operand this cycle |
| ld_wgt | input | 1 | 1 writes a weight, 0 writes an activation |
| ld_idx | input | 3 | Lane index of the write |
| ld_data | input | 8 | Operand value |
| start | input | 1 | Launch a run (ignored while busy) |
| len_code | input | 3 | Stream length code, sampled at start |
| merge_mux | input | 1 | Group adder mode, sampled at start (0 OR, 1 scaled) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 10 | Sum of the group counters |

## Verification
The lane is run with mixed operands in both merge modes, and each result is compared against a bit-exact stream model. That comparison separates a wrong tap set, a missing bit reversal, a swapped comparator sense and an OR merge confused with a mux merge. All-zero and all-255 operands pin the comparator edges. Every length code, including the three aliases of 256, is run to fix the `done` timing. A run disturbed by a mid-run start and a mid-run load is then repeated undisturbed, which shows that neither reached the lane's state. A sparse pattern with one active lane per group is compared against the ideal dot product, to show that the shared random source still gives a usable estimate.

// File: rtl/sc_mac_pkg.sv
// Package: shared widths, merge mode type and helpers for the stochastic lane.
// Assumes 8-bit operands and an 8-bit random source.
package sc_mac_pkg;
    localparam int unsigned OPND_W  = 8;
    localparam int unsigned RNG_W   = 8;
    localparam int unsigned MAX_LEN = 256;
    localparam int unsigned CNT_W   = $clog2(MAX_LEN) + 1;

    typedef logic [OPND_W-1:0] opnd_t;
    typedef logic [RNG_W-1:0]  rng_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic {
        MERGE_OR  = 1'b0,
        MERGE_MUX = 1'b1
    } merge_e;

    // Map a length code to a stream length; codes above 4 alias the maximum.
    function automatic cnt_t len_of(input logic [2:0] code);
        case (code)
            3'd0:    len_of = cnt_t'(16);
            3'd1:    len_of = cnt_t'(32);
            3'd2:    len_of = cnt_t'(64);
            3'd3:    len_of = cnt_t'(128);
            default: len_of = cnt_t'(MAX_LEN);
        endcase
    endfunction

    // Reverse bit order of a random value to decorrelate weight streams.
    function automatic rng_t bit_rev(input rng_t v);
        for (int i = 0; i < RNG_W; i++) bit_rev[i] = v[RNG_W-1-i];
    endfunction
endpackage

// File: rtl/sc_lfsr.sv
// Module: sc_lfsr
// Maximal-length 8-bit Fibonacci LFSR (x^8+x^6+x^5+x^4+1) shared by all
// stream generators. Assumes SEED is nonzero; the zero state is unreachable.
module sc_lfsr
    import sc_mac_pkg::*;
#(
    parameter rng_t SEED = 8'hA5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic seed_i,
    input  logic step_i,
    output rng_t state_o
);
    rng_t state_q;
    logic fb;

    // Feedback from taps 8,6,5,4.
    assign fb = state_q[7] ^ state_q[5] ^ state_q[4] ^ state_q[3];

    // Reseed on request, otherwise advance while stepping.
    always_ff @(posedge clk) begin
        if (!rst_n)      state_q <= SEED;
        else if (seed_i) state_q <= SEED;
        else if (step_i) state_q <= {state_q[RNG_W-2:0], fb};
    end

    assign state_o = state_q;

    p_lfsr_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
endmodule

// File: rtl/sc_stream_gen.sv
// Module: sc_stream_gen
// One lane: compares activation with the random value and weight with its
// bit-reversed copy, then ANDs the two unipolar bits into a product bit.
// Assumes the random value changes every run cycle.
module sc_stream_gen
    import sc_mac_pkg::*;
(
    input  opnd_t act_i,
    input  opnd_t wgt_i,
    input  rng_t  rnd_i,
    output logic  prod_o
);
    logic a_bit, w_bit;

    // Comparator-based stream bits and their product.
    always_comb begin
        a_bit  = act_i > rnd_i;
        w_bit  = wgt_i > bit_rev(rnd_i);
        prod_o = a_bit & w_bit;
    end
endmodule

// File: rtl/sc_group_adder.sv
// Module: sc_group_adder
// Stochastic adder for one group of product bits: OR merge (saturating sum)
// or scaled mux merge driven by select bits. Assumes GROUP is a power of two.
module sc_group_adder
    import sc_mac_pkg::*;
#(
    parameter int unsigned GROUP = 4,
    localparam int unsigned SEL_W = (GROUP > 1) ? $clog2(GROUP) : 1
) (
    input  merge_e             mode_i,
    input  logic [GROUP-1:0]   prod_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               y_o
);
    generate
        if (GROUP == 1) begin : g_single
            // A single product passes straight through in either mode.
            assign y_o = prod_i[0];
        end else begin : g_multi
            // Pick the merge selected for this run.
            always_comb begin
                if (mode_i == MERGE_MUX) y_o = prod_i[sel_i];
                else                     y_o = |prod_i;
            end
        end
    endgenerate
endmodule

// File: rtl/sc_mac_lane.sv
// Module: sc_mac_lane (top)
// Stochastic dot-product lane with hybrid accumulation: groups of product
// streams are merged stochastically, group bits are counted exactly.
// Assumes N_LANES is a multiple of GROUP and loads happen while idle.
module sc_mac_lane
    import sc_mac_pkg::*;
#(
    parameter int unsigned N_LANES = 8,
    parameter int unsigned GROUP   = 4,
    parameter rng_t        SEED    = 8'hA5,
    localparam int unsigned N_GRP  = N_LANES / GROUP,
    localparam int unsigned IDX_W  = $clog2(N_LANES),
    localparam int unsigned SEL_W  = (GROUP > 1) ? $clog2(GROUP) : 1,
    localparam int unsigned RES_W  = CNT_W + $clog2(N_GRP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic             ld_wgt,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [7:0]       ld_data,
    input  logic             start,
    input  logic [2:0]       len_code,
    input  logic             merge_mux,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] result
);
    opnd_t             act_q [N_LANES];
    opnd_t             wgt_q [N_LANES];
    logic              busy_q, done_q;
    cnt_t              remain_q;
    merge_e            mode_q;
    rng_t              rnd;
    logic [N_LANES-1:0] prod;
    logic [N_GRP-1:0]  gbit;
    cnt_t              gcnt_q [N_GRP];
    logic              go;

    assign go = start && !busy_q;

    // Operand registers; writes are dropped while a run is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_LANES; i++) begin
                act_q[i] <= '0;
                wgt_q[i] <= '0;
            end
        end else if (ld_en && !busy_q) begin
            if (ld_wgt) wgt_q[ld_idx] <= ld_data;
            else        act_q[ld_idx] <= ld_data;
        end
    end

    // Run control: length countdown, busy flag and one-cycle done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            remain_q <= '0;
            mode_q   <= MERGE_OR;
        end else begin
            done_q <= 1'b0;
            if (go) begin
                busy_q   <= 1'b1;
                remain_q <= len_of(len_code) - cnt_t'(1);
                mode_q   <= merge_e'(merge_mux);
            end else if (busy_q) begin
                if (remain_q == '0) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    remain_q <= remain_q - cnt_t'(1);
                end
            end
        end
    end

    sc_lfsr #(.SEED(SEED)) u_rng (
        .clk     (clk),
        .rst_n   (rst_n),
        .seed_i  (go),
        .step_i  (busy_q),
        .state_o (rnd)
    );

    generate
        for (genvar l = 0; l < N_LANES; l++) begin : g_lane
            sc_stream_gen u_gen (
                .act_i  (act_q[l]),
                .wgt_i  (wgt_q[l]),
                .rnd_i  (rnd),
                .prod_o (prod[l])
            );

            p_load_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
                busy_q |=> $stable(act_q[l]) && $stable(wgt_q[l]));
        end

        for (genvar g = 0; g < N_GRP; g++) begin : g_grp
            sc_group_adder #(.GROUP(GROUP)) u_add (
                .mode_i (mode_q),
                .prod_i (prod[g*GROUP +: GROUP]),
                .sel_i  (rnd[SEL_W-1:0]),
                .y_o    (gbit[g])
            );

            // Exact binary count of the group's merged stream.
            always_ff @(posedge clk) begin
                if (!rst_n)      gcnt_q[g] <= '0;
                else if (go)     gcnt_q[g] <= '0;
                else if (busy_q) gcnt_q[g] <= gcnt_q[g] + cnt_t'(gbit[g]);
            end

            p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
                gcnt_q[g] <= cnt_t'(MAX_LEN));
            p_or_merge_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (busy_q && mode_q == MERGE_OR && |prod[g*GROUP +: GROUP]) |-> gbit[g]);
            p_mux_merge_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (busy_q && gbit[g]) |-> |prod[g*GROUP +: GROUP]);
        end
    endgenerate

    // Sum of the group counters forms the binary result.
    always_comb begin
        result = '0;
        for (int g = 0; g < N_GRP; g++) result = result + RES_W'(gcnt_q[g]);
    end

    assign busy = busy_q;
    assign done = done_q;

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    p_done_after_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q && $past(busy_q));
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start && remain_q != '0) |=> busy_q && remain_q == $past(remain_q) - cnt_t'(1));
    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !go) |=> $stable(result));
endmodule

// File: tb/sc_mac_lane_test.sv
`timescale 1ns/1ps
module sc_mac_lane_test;
    localparam int NL = 8;
    localparam int GR = 4;
    localparam int NG = NL / GR;
    localparam logic [7:0] SEED = 8'hA5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_en = 1'b0, ld_wgt = 1'b0;
    logic [2:0] ld_idx = '0;
    logic [7:0] ld_data = '0;
    logic       start = 1'b0;
    logic [2:0] len_code = '0;
    logic       merge_mux = 1'b0;
    logic       busy, done;
    logic [9:0] result;

    int n_checks = 0;
    int n_fail = 0;
    int a_m [NL];
    int w_m [NL];

    always #2 clk = ~clk;

    sc_mac_lane uut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_wgt(ld_wgt), .ld_idx(ld_idx),
        .ld_data(ld_data), .start(start), .len_code(len_code), .merge_mux(merge_mux),
        .busy(busy), .done(done), .result(result)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int len_map(input int code);
        case (code)
            0: return 16;
            1: return 32;
            2: return 64;
            3: return 128;
            default: return 256;
        endcase
    endfunction

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    // Stream model written from R2-R5 and R7.
    function automatic int model(input bit mux, input int len);
        logic [7:0] s = SEED;
        int tot = 0;
        for (int k = 0; k < len; k++) begin
            for (int g = 0; g < NG; g++) begin
                bit gb = 1'b0;
                for (int j = 0; j < GR; j++) begin
                    int ln = g * GR + j;
                    bit p = (a_m[ln] > int'(s)) && (w_m[ln] > int'(rev8(s)));
                    if (mux) begin
                        if (j == int'(s[1:0])) gb = p;
                    end else gb = gb | p;
                end
                tot += int'(gb);
            end
            s = {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
        end
        return tot;
    endfunction

    task automatic load(input bit wgt, input int idx, input int val);
        @(negedge clk);
        ld_en = 1'b1; ld_wgt = wgt; ld_idx = 3'(idx); ld_data = 8'(val);
        @(negedge clk);
        ld_en = 1'b0;
        if (wgt) w_m[idx] = val; else a_m[idx] = val;
    endtask

    task automatic load_all(input int a [NL], input int w [NL]);
        for (int i = 0; i < NL; i++) begin
            load(1'b0, i, a[i]);
            load(1'b1, i, w[i]);
        end
    endtask

    // Launch a run, optionally disturb it mid-run, check timing and result.
    task automatic run(input bit mux, input int code, input bit disturb,
                       input string tag, output int res);
        int len = len_map(code);
        int exp = model(mux, len);
        @(negedge clk);
        start = 1'b1; merge_mux = mux; len_code = 3'(code);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, {tag, " R6 busy after start"}, int'(busy), 1);
        for (int c = 1; c < len; c++) begin
            if (disturb && c == 10) begin
                start = 1'b1; ld_en = 1'b1; ld_wgt = 1'b0; ld_idx = 3'd0; ld_data = 8'd7;
            end else begin
                start = 1'b0; ld_en = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0; ld_en = 1'b0;
        check(done == 1'b0 && busy == 1'b1, {tag, " R6 still running on last cycle"}, int'(done), 0);
        @(negedge clk);
        check(done == 1'b1 && busy == 1'b0, {tag, " R6 done one cycle after last bit"}, int'(done), 1);
        check(int'(result) == exp, {tag, " R7 result"}, int'(result), exp);
        res = int'(result);
        @(negedge clk);
        check(done == 1'b0, {tag, " R6 done is one cycle"}, int'(done), 0);
        check(int'(result) == exp, {tag, " R7 result held"}, int'(result), exp);
    endtask

    task automatic t_reset();
        check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        check(done == 1'b0, "R1 done after reset", int'(done), 0);
        check(result == '0, "R1 result after reset", int'(result), 0);
    endtask

    task automatic t_or_mixed();
        int r;
        load_all('{200, 17, 90, 0, 255, 128, 33, 64}, '{50, 250, 100, 77, 3, 128, 160, 201});
        run(1'b0, 2, 1'b0, "R2 R4 mixed OR", r);
        run(1'b0, 4, 1'b0, "R2 R4 mixed OR 256", r);
    endtask

    task automatic t_mux();
        int r;
        run(1'b1, 3, 1'b0, "R5 mixed mux", r);
        load_all('{10, 240, 130, 66, 255, 1, 99, 180}, '{255, 128, 64, 200, 140, 255, 30, 90});
        run(1'b1, 4, 1'b0, "R5 second mux", r);
    endtask

    task automatic t_reseed();
        int r1, r2;
        run(1'b0, 1, 1'b0, "R3 first", r1);
        run(1'b0, 1, 1'b0, "R3 repeat", r2);
        check(r1 == r2, "R3 reseed gives identical run", r2, r1);
    endtask

    task automatic t_lengths();
        int r;
        load_all('{255, 255, 255, 255, 255, 255, 255, 255}, '{255, 255, 255, 255, 255, 255, 255, 255});
        for (int c = 0; c < 8; c++) run(1'b0, c, 1'b0, "R6 R9 length code", r);
    endtask

    task automatic t_zero();
        int r;
        load_all('{0, 0, 0, 0, 0, 0, 0, 0}, '{0, 0, 0, 0, 0, 0, 0, 0});
        run(1'b0, 4, 1'b0, "R9 zero OR", r);
        check(r == 0, "R9 zero operands", r, 0);
        run(1'b1, 0, 1'b0, "R9 zero mux", r);
    endtask

    task automatic t_busy_ignore();
        int r1, r2;
        load_all('{150, 60, 0, 220, 45, 190, 5, 128}, '{99, 180, 255, 12, 240, 70, 128, 255});
        run(1'b0, 3, 1'b1, "R8 disturbed run", r1);
        run(1'b0, 3, 1'b0, "R8 later run unchanged", r2);
        check(r1 == r2, "R8 load while busy had no effect", r2, r1);
    endtask

    task automatic t_accuracy();
        int r, ideal, diff;
        load_all('{128, 0, 0, 0, 192, 0, 0, 0}, '{128, 0, 0, 0, 64, 0, 0, 0});
        run(1'b0, 4, 1'b0, "R10 sparse", r);
        ideal = (128 * 128 + 192 * 64) / 256;
        diff = (r > ideal) ? r - ideal : ideal - r;
        check(diff <= 6, "R10 accuracy at length 256", r, ideal);
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NL; i++) begin
            a_m[i] = 0;
            w_m[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_or_mixed();
        t_mux();
        t_reseed();
        t_lengths();
        t_zero();
        t_busy_ignore();
        t_accuracy();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule